// File: doc/BRIEF.md
# Keypad Combination Lock Controller

This block is the decision core of a four-digit combination lock. It takes key events that have already been debounced and decoded, each one a single-cycle pulse. A key event is either a decimal digit or one of four commands: clear, change code, lock and unlock. The block keeps a four-digit entry register and a stored code. It drives a lock status output and a one-cycle error pulse. It also presents the entry digits as BCD nibbles so that an external display driver can show them.

Digits enter the entry register from the right, and older digits move one place to the left. The same entry register serves three purposes: it supplies the new code on a change, it is wiped on a clear, and it is compared with the stored code on an unlock. Scanning, debouncing, display multiplexing and segment decoding are done outside this block.

Top module: `comboLockCore`

## Requirements
- R1: After reset the entry register reads 0000, the stored code is 0000, `isLocked` is 0 and `errPulse` is 0.
- R2: A `digitValid` pulse with a code from 0 to 9 puts that code in digit position 0, which is bits [3:0] of `entryDigits` and the rightmost place on the display. Position i moves to position i+1, and the old position 3 (bits [15:12]) is dropped. The new value appears on the clock edge that samples the pulse.
- R3: A `digitValid` pulse with a code from 10 to 15 leaves the entry register unchanged.
- R4: `clearCmd` sets every entry digit to 0.
- R5: `changeCmd` while unlocked copies the four entry digits into the stored code.
- R6: `changeCmd` while locked leaves the stored code unchanged.
- R7: `lockCmd` sets `isLocked` to 1.
- R8: `unlockCmd` clears `isLocked` when all four entry digits equal the stored code.
- R9: `unlockCmd` with any digit mismatch leaves `isLocked` unchanged and raises `errPulse` for exactly one cycle.
- R10: The entry register reads 0000 after every lock, unlock or change-code command, whatever its outcome.
- R11: When several inputs pulse in the same cycle, only the highest-priority one acts. The order from highest to lowest is clear, unlock, lock, change code, digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| digitValid | input | 1 | Single-cycle digit key event |
| digitCode | input | 4 | Key code that goes with `digitValid` |
| clearCmd | input | 1 | Single-cycle clear event |
| changeCmd | input | 1 | Single-cycle change-code event |
| lockCmd | input | 1 | Single-cycle lock event |
| unlockCmd | input | 1 | Single-cycle unlock event |
| isLocked | output | 1 | 1 while locked |
| errPulse | output | 1 | One-cycle pulse after a failed unlock |
| entryDigits | output | 16 | Entry digits in BCD; digit i is at bits [4i+3:4i] |

## Verification
Unlock and lock are the two commands most likely to collide. If they arrive together and unlock is taken wrongly, a correct code can leave the lock closed, and a wrong code can lose its error pulse. Likewise a digit that arrives together with a command can corrupt the cleared entry register. The bench drives every one of the 32 combinations of the five input pulses in a single cycle. It does this from both lock states, and with an entry that either matches or misses the stored code. A model built from the priority rule decides which single action should win. The bench then compares the entry, the lock status and the error pulse against that model on the following cycle.

// File: rtl/lockPkg.sv
package lockPkg;
  localparam int DIGIT_W   = 4;
  localparam int MAX_DIGIT = 9;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CLEAR,
    SEL_UNLOCK,
    SEL_LOCK,
    SEL_CHANGE,
    SEL_DIGIT
  } keySel_t;

  typedef struct packed {
    logic clearEntry;
    logic shiftDigit;
    logic storeCode;
  } entryStrobe_t;
endpackage

// File: rtl/lockCtrl.sv
module lockCtrl
  import lockPkg::*;
#(
  parameter int CODE_W = DIGIT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              digitValid,
  input  logic [CODE_W-1:0] digitCode,
  input  logic              clearCmd,
  input  logic              changeCmd,
  input  logic              lockCmd,
  input  logic              unlockCmd,
  input  logic              codeMatch,
  output entryStrobe_t      strobe,
  output logic              isLocked,
  output logic              errPulse
);
  localparam logic [CODE_W-1:0] DIGIT_LIMIT = CODE_W'(MAX_DIGIT);

  keySel_t sel;
  logic lockQ, lockD;
  logic errQ, errD;

  // Fixed priority among simultaneous key events
  always_comb begin
    if (clearCmd)                                  sel = SEL_CLEAR;
    else if (unlockCmd)                            sel = SEL_UNLOCK;
    else if (lockCmd)                              sel = SEL_LOCK;
    else if (changeCmd)                            sel = SEL_CHANGE;
    else if (digitValid && digitCode <= DIGIT_LIMIT) sel = SEL_DIGIT;
    else                                           sel = SEL_NONE;
  end

  always_comb begin
    strobe = '0;
    lockD  = lockQ;
    errD   = 1'b0;
    unique case (sel)
      SEL_CLEAR:  strobe.clearEntry = 1'b1;
      SEL_UNLOCK: begin
        strobe.clearEntry = 1'b1;
        if (codeMatch) lockD = 1'b0;
        else           errD  = 1'b1;
      end
      SEL_LOCK: begin
        strobe.clearEntry = 1'b1;
        lockD             = 1'b1;
      end
      SEL_CHANGE: begin
        strobe.clearEntry = 1'b1;
        strobe.storeCode  = ~lockQ;
      end
      SEL_DIGIT:  strobe.shiftDigit = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      lockQ <= lockD;
      errQ  <= errD;
    end
  end

  assign isLocked = lockQ;
  assign errPulse = errQ;
endmodule

// File: rtl/lockData.sv
module lockData
  import lockPkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int CODE_W     = DIGIT_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  entryStrobe_t                 strobe,
  input  logic [CODE_W-1:0]            digitIn,
  output logic [NUM_DIGITS*CODE_W-1:0] entryFlat,
  output logic [NUM_DIGITS*CODE_W-1:0] storedFlat,
  output logic                         codeMatch
);
  logic [CODE_W-1:0] entryQ  [NUM_DIGITS];
  logic [CODE_W-1:0] storedQ [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] digitEq;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    logic [CODE_W-1:0] shiftSrc;
    if (i == 0) begin : g_right
      assign shiftSrc = digitIn;
    end else begin : g_inner
      assign shiftSrc = entryQ[i-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   entryQ[i] <= '0;
      else if (strobe.clearEntry)  entryQ[i] <= '0;
      else if (strobe.shiftDigit)  entryQ[i] <= shiftSrc;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  storedQ[i] <= '0;
      else if (strobe.storeCode)  storedQ[i] <= entryQ[i];
    end

    assign digitEq[i] = (entryQ[i] == storedQ[i]);
    assign entryFlat[i*CODE_W +: CODE_W]  = entryQ[i];
    assign storedFlat[i*CODE_W +: CODE_W] = storedQ[i];
  end

  assign codeMatch = &digitEq;
endmodule

// File: rtl/comboLockCore.sv
module comboLockCore
  import lockPkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int CODE_W     = DIGIT_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         digitValid,
  input  logic [CODE_W-1:0]            digitCode,
  input  logic                         clearCmd,
  input  logic                         changeCmd,
  input  logic                         lockCmd,
  input  logic                         unlockCmd,
  output logic                         isLocked,
  output logic                         errPulse,
  output logic [NUM_DIGITS*CODE_W-1:0] entryDigits
);
  entryStrobe_t strobe;
  logic codeMatch;
  logic [NUM_DIGITS*CODE_W-1:0] storedFlat;

  lockCtrl #(.CODE_W(CODE_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .digitValid(digitValid), .digitCode(digitCode),
    .clearCmd(clearCmd), .changeCmd(changeCmd),
    .lockCmd(lockCmd), .unlockCmd(unlockCmd),
    .codeMatch(codeMatch), .strobe(strobe),
    .isLocked(isLocked), .errPulse(errPulse)
  );

  lockData #(.NUM_DIGITS(NUM_DIGITS), .CODE_W(CODE_W)) uData (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .digitIn(digitCode),
    .entryFlat(entryDigits), .storedFlat(storedFlat),
    .codeMatch(codeMatch)
  );
endmodule

// File: rtl/comboLockChk.sv
module comboLockChk #(
  parameter int NUM_DIGITS = 4,
  parameter int CODE_W     = 4
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         digitValid,
  input logic [CODE_W-1:0]            digitCode,
  input logic                         clearCmd,
  input logic                         changeCmd,
  input logic                         lockCmd,
  input logic                         unlockCmd,
  input logic                         isLocked,
  input logic                         errPulse,
  input logic [NUM_DIGITS*CODE_W-1:0] entryDigits,
  input logic [NUM_DIGITS*CODE_W-1:0] storedFlat
);
  localparam int W = NUM_DIGITS * CODE_W;
  logic anyCmd;
  assign anyCmd = clearCmd | changeCmd | lockCmd | unlockCmd;

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> entryDigits == '0); // R4

  AST_CMD_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (unlockCmd || lockCmd || changeCmd) |=> entryDigits == '0); // R10

  AST_DIGIT_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (!anyCmd && digitValid && digitCode <= CODE_W'(9))
      |=> entryDigits == {$past(entryDigits[W-CODE_W-1:0]), $past(digitCode)}); // R2

  AST_BAD_KEY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!anyCmd && digitValid && digitCode > CODE_W'(9)) |=> $stable(entryDigits)); // R3

  AST_LOCKED_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (changeCmd && isLocked) |=> $stable(storedFlat)); // R6

  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (lockCmd && !clearCmd && !unlockCmd) |=> isLocked); // R7

  AST_MATCH_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (unlockCmd && !clearCmd && entryDigits == storedFlat) |=> !isLocked && !errPulse); // R8

  AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (unlockCmd && !clearCmd && entryDigits != storedFlat) |=> errPulse && $stable(isLocked)); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(unlockCmd && !clearCmd)); // R11

  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isLocked) |-> $past(lockCmd && !clearCmd && !unlockCmd)); // R11
endmodule

bind comboLockCore comboLockChk #(.NUM_DIGITS(NUM_DIGITS), .CODE_W(CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .digitValid(digitValid), .digitCode(digitCode),
  .clearCmd(clearCmd), .changeCmd(changeCmd), .lockCmd(lockCmd),
  .unlockCmd(unlockCmd), .isLocked(isLocked), .errPulse(errPulse),
  .entryDigits(entryDigits), .storedFlat(storedFlat)
);

// File: tb/comboLockCore_bench.sv
`timescale 1ns/1ps
module comboLockCore_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic digitValid = 1'b0;
  logic [3:0] digitCode = '0;
  logic clearCmd = 1'b0, changeCmd = 1'b0, lockCmd = 1'b0, unlockCmd = 1'b0;
  logic isLocked, errPulse;
  logic [15:0] entryDigits;

  int total = 0;
  int bad = 0;

  logic [15:0] expEntry = '0;
  logic [15:0] expStored = '0;
  logic expLocked = 1'b0;
  logic expErr = 1'b0;

  always #10 clk = ~clk;

  comboLockCore u_comboLockCore (
    .clk(clk), .rstN(rstN), .digitValid(digitValid), .digitCode(digitCode),
    .clearCmd(clearCmd), .changeCmd(changeCmd), .lockCmd(lockCmd),
    .unlockCmd(unlockCmd), .isLocked(isLocked), .errPulse(errPulse),
    .entryDigits(entryDigits)
  );

  task automatic checkAll(input string tag);
    total++;
    if (entryDigits !== expEntry) begin
      bad++;
      $display("FAIL %s entry act=%h exp=%h", tag, entryDigits, expEntry);
    end
    total++;
    if (isLocked !== expLocked) begin
      bad++;
      $display("FAIL %s locked act=%b exp=%b", tag, isLocked, expLocked);
    end
    total++;
    if (errPulse !== expErr) begin
      bad++;
      $display("FAIL %s err act=%b exp=%b", tag, errPulse, expErr);
    end
  endtask

  // One key cycle: drive after a falling edge, sample at the next falling edge
  task automatic step(input string tag, input logic clr, input logic unl,
                      input logic lck, input logic chg, input logic dv,
                      input logic [3:0] dc);
    @(negedge clk);
    clearCmd = clr; unlockCmd = unl; lockCmd = lck; changeCmd = chg;
    digitValid = dv; digitCode = dc;
    expErr = 1'b0;
    if (clr) expEntry = '0;
    else if (unl) begin
      if (expEntry == expStored) expLocked = 1'b0;
      else expErr = 1'b1;
      expEntry = '0;
    end else if (lck) begin
      expLocked = 1'b1;
      expEntry = '0;
    end else if (chg) begin
      if (!expLocked) expStored = expEntry;
      expEntry = '0;
    end else if (dv && dc <= 4'd9) expEntry = {expEntry[11:0], dc};
    @(negedge clk);
    clearCmd = 0; unlockCmd = 0; lockCmd = 0; changeCmd = 0;
    digitValid = 0; digitCode = '0;
    checkAll(tag);
    expErr = 1'b0;
  endtask

  task automatic enterCode(input string tag, input logic [15:0] c);
    for (int i = 3; i >= 0; i--) step(tag, 0, 0, 0, 0, 1, c[i*4 +: 4]);
  endtask

  function automatic logic [15:0] toBcd(input int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic forceOpen();
    if (expLocked) begin
      enterCode("R8 reopen", expStored);
      step("R8 reopen", 0, 1, 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // stored code after reset is 0000: lock then unlock with empty entry
    step("R7 lock", 0, 0, 1, 0, 0, 0);
    step("R1 R8 default code", 0, 1, 0, 0, 0, 0);

    // all 16 key codes, shifting and drop of the leftmost digit
    for (int k = 0; k < 16; k++) step("R2 R3 key sweep", 0, 0, 0, 0, 1, 4'(k));
    enterCode("R2 overflow", 16'h9876);
    step("R2 drop", 0, 0, 0, 0, 1, 4'd5);
    step("R3 bad key", 0, 0, 0, 0, 1, 4'd12);
    step("R4 clear", 1, 0, 0, 0, 0, 0);

    // code sweep
    for (int n = 0; n < 200; n++) begin
      logic [15:0] code, other;
      code  = toBcd((n * 4271 + 17) % 10000);
      other = toBcd((n * 4271 + 18) % 10000);
      forceOpen();
      enterCode("R5 set", code);
      step("R5 R10 change", 0, 0, 0, 1, 0, 0);
      step("R7 lock", 0, 0, 1, 0, 0, 0);
      enterCode("R6 try", other);
      step("R6 R10 change locked", 0, 0, 0, 1, 0, 0);
      enterCode("R9 wrong", other);
      step("R9 miss", 0, 1, 0, 0, 0, 0);
      step("R9 pulse ends", 0, 0, 0, 0, 0, 0);
      enterCode("R8 right", code);
      step("R8 R10 open", 0, 1, 0, 0, 0, 0);
    end

    // simultaneous events: all 32 combinations
    for (int lk = 0; lk < 2; lk++)
      for (int mt = 0; mt < 2; mt++)
        for (int m = 0; m < 32; m++) begin
          forceOpen();
          enterCode("R11 prep", 16'h1234);
          step("R11 prep", 0, 0, 0, 1, 0, 0);
          if (lk != 0) step("R11 prep", 0, 0, 1, 0, 0, 0);
          enterCode("R11 prep", mt != 0 ? 16'h1234 : 16'h1235);
          step("R11 combo", m[4], m[3], m[2], m[1], m[0], 4'd7);
          step("R11 after", 0, 0, 0, 0, 0, 0);
        end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule